// File: doc/BRIEF.md
# PLL Reconfiguration Register Sequencer

This block reprograms one PLL by driving its two control registers through a simple write port made of address, data and a write strobe. On an accepted start it works out a table index from the input-clock index and, when that option is on, a silicon-revision index. It reads the multiplier, pre-divider, post-divider and frequency-range setting for that index from a parameter table.

It then runs a fixed sequence:
- It puts the PLL into bypass and waits for the lock status to drop.
- It programs the divider word. When the workaround is on, it first writes a post-divider one above the target and then the true value.
- It writes the frequency-range field.
- It selects lock mode and waits for the lock status to rise.

Each status wait is bounded by a cycle limit that the caller supplies. If the limit runs out, the sequence stops and the error flag is raised. The block keeps a shadow copy of both registers, so every write is a read-modify-write that leaves untouched bits as they were. The done and error flags stay set until the caller clears them. No new sequence can start while a sequence runs or while a flag is still set.

Top module: `pll_reseq`

## Requirements
- R1: After reset, done_o, err_o and wr_en_o are 0. The shadow of the enable register (address 0x0) holds 32'h1234_5608 and the shadow of the control register (address 0x4) holds 32'h0000_8047.
- R2: At an accepted start the table index is clk_idx_i when rev_sel_i is 0, and 3*clk_idx_i + rev_idx_i when rev_sel_i is 1.
- R3: Table entry i holds multiplier 150+9*i (11 bits), pre-divider (i mod 16)+1 (7 bits), post-divider (i mod 5)+1 (5 bits) and frequency range (i+3) mod 16 (4 bits).
- R4: The first write of a sequence goes to the enable register. It sets the mode field [2:0] to the bypass code 3'b101 and keeps all other bits. The block then waits for status_i to read 0.
- R5: The divider write goes to the control register. It places the post-divider in [31:27], the multiplier in [26:16] and the pre-divider in [14:8], and keeps bits 15 and 7:0.
- R6: With wa_en_i set at start, the control register is written twice on consecutive cycles: first with the post-divider plus one (5-bit wrap), then with the true value. Without the workaround it is written once.
- R7: After the divider writes, the enable register is written with the frequency range in [7:4]. On the next cycle a write sets the mode field to the lock code 3'b111. A write sequence therefore has 4 writes, or 5 with the workaround.
- R8: After the lock write, done_o rises once status_i reads 1, and no further writes follow.
- R9: Each wait samples status_i at most wait_lim_i+1 times. If the target level is not seen, err_o rises and no further writes are issued. An unlock timeout leaves the bypass write as the only write.
- R10: If status_i reaches the target level in the same cycle that the wait limit expires, the sequence continues as a success.
- R11: start_i is ignored while a sequence runs or while done_o or err_o is set. clear_i clears both flags, and a start in the same cycle as clear_i is still ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request |
| clear_i | input | 1 | Clears done_o and err_o |
| clk_idx_i | input | CLK_IW | Input-clock index |
| rev_sel_i | input | 1 | Use revision-based indexing |
| rev_idx_i | input | REV_IW | Silicon-revision index |
| wa_en_i | input | 1 | Enable the double-write workaround |
| wait_lim_i | input | LIM_W | Cycle limit for each status wait |
| status_i | input | 1 | PLL lock status (1 = locked) |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | AW | Register write address |
| wr_data_o | output | 32 | Register write data |
| done_o | output | 1 | Sequence finished with lock |
| err_o | output | 1 | A status wait timed out |

## Verification
Two things can fall in the same cycle in this block: the status reaching its target level and the wait counter reaching its limit. The PLL model in the bench changes status a set delay after each mode write. A delay of limit minus two makes the status arrive exactly as the limit expires, and the bench expects done rather than an error. A delay one cycle longer must end in an error. The second collision is between start and clear. The bench drives them together and then checks that the flags are cleared and that no write appears.

// File: rtl/pll_reseq_pkg.sv
package pll_reseq_pkg;

  localparam int DW = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BYP,
    ST_WUNL,
    ST_DIVP1,
    ST_DIV,
    ST_FSEL,
    ST_LOCK,
    ST_WLCK
  } seq_st_t;

  typedef enum logic [1:0] {
    WK_NONE,
    WK_MODE,
    WK_FSEL,
    WK_CTL
  } wr_kind_t;

  typedef struct packed {
    logic [4:0]  post;
    logic [10:0] mult;
    logic [6:0]  pre;
    logic [3:0]  frange;
  } pll_cfg_t;

endpackage

// File: rtl/pll_reseq_rom.sv
module pll_reseq_rom
  import pll_reseq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int M_BASE = 150,
  parameter int M_STEP = 9,
  localparam int TAW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rd_en,
  input  logic [TAW-1:0] addr,
  output pll_cfg_t       q
);

  function automatic pll_cfg_t entry_f(int i);
    pll_cfg_t e;
    e.mult   = 11'(M_BASE + M_STEP * i);
    e.pre    = 7'((i % 16) + 1);
    e.post   = 5'((i % 5) + 1);
    e.frange = 4'((i + 3) % 16);
    return e;
  endfunction

  // registered read, so the table maps onto a synchronous ROM
  always_ff @(posedge clk) begin
    if (rd_en) q <= entry_f(int'(addr));
  end

endmodule

// File: rtl/pll_reseq_tmr.sv
module pll_reseq_tmr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)           cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == limit);

endmodule

// File: rtl/pll_reseq_wr.sv
module pll_reseq_wr
  import pll_reseq_pkg::*;
#(
  parameter int             AW       = 4,
  parameter logic [AW-1:0]  EN_ADDR  = 4'h0,
  parameter logic [AW-1:0]  CTL_ADDR = 4'h4,
  parameter logic [DW-1:0]  EN_INIT  = 32'h1234_5608,
  parameter logic [DW-1:0]  CTL_INIT = 32'h0000_8047
) (
  input  logic          clk,
  input  logic          rst,
  input  wr_kind_t      kind,
  input  logic [2:0]    mode,
  input  logic [3:0]    frange,
  input  logic [4:0]    post,
  input  logic [10:0]   mult,
  input  logic [6:0]    pre,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);

  logic [DW-1:0] sh_en, sh_ctl;
  logic [DW-1:0] en_nxt, ctl_nxt;

  always_comb begin
    en_nxt  = sh_en;
    ctl_nxt = sh_ctl;
    case (kind)
      WK_MODE: en_nxt[2:0] = mode;
      WK_FSEL: en_nxt[7:4] = frange;
      WK_CTL: begin
        ctl_nxt[31:27] = post;
        ctl_nxt[26:16] = mult;
        ctl_nxt[14:8]  = pre;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_en     <= EN_INIT;
      sh_ctl    <= CTL_INIT;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= (kind != WK_NONE);
      if (kind == WK_CTL) begin
        sh_ctl    <= ctl_nxt;
        wr_addr_o <= CTL_ADDR;
        wr_data_o <= ctl_nxt;
      end else if (kind != WK_NONE) begin
        sh_en     <= en_nxt;
        wr_addr_o <= EN_ADDR;
        wr_data_o <= en_nxt;
      end
    end
  end

endmodule

// File: rtl/pll_reseq.sv
module pll_reseq
  import pll_reseq_pkg::*;
#(
  parameter int             CLK_IW    = 3,
  parameter int             REV_IW    = 2,
  parameter int             LIM_W     = 16,
  parameter int             TBL_DEPTH = 32,
  parameter int             AW        = 4,
  parameter logic [AW-1:0]  EN_ADDR   = 4'h0,
  parameter logic [AW-1:0]  CTL_ADDR  = 4'h4,
  parameter logic [31:0]    EN_INIT   = 32'h1234_5608,
  parameter logic [31:0]    CTL_INIT  = 32'h0000_8047,
  parameter logic [2:0]     BYP_CODE  = 3'b101,
  parameter logic [2:0]     LOCK_CODE = 3'b111,
  parameter int             M_BASE    = 150,
  parameter int             M_STEP    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic [CLK_IW-1:0] clk_idx_i,
  input  logic              rev_sel_i,
  input  logic [REV_IW-1:0] rev_idx_i,
  input  logic              wa_en_i,
  input  logic [LIM_W-1:0]  wait_lim_i,
  input  logic              status_i,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int TAW = $clog2(TBL_DEPTH);

  seq_st_t          state;
  logic             busy, accept;
  logic             wa_q;
  logic [LIM_W-1:0] lim_q;
  logic [TAW-1:0]   tbl_idx;
  pll_cfg_t         cfg;
  wr_kind_t         kind;
  logic [2:0]       mode;
  logic [4:0]       post;
  logic             tmr_clr, tmr_run, tmr_exp;

  assign busy   = (state != ST_IDLE);
  assign accept = (state == ST_IDLE) && start_i && !done_o && !err_o;

  always_comb begin
    if (rev_sel_i) tbl_idx = TAW'(3 * int'(clk_idx_i) + int'(rev_idx_i));
    else           tbl_idx = TAW'(clk_idx_i);
  end

  pll_reseq_rom #(
    .DEPTH (TBL_DEPTH),
    .M_BASE(M_BASE),
    .M_STEP(M_STEP)
  ) u_rom (
    .clk  (clk),
    .rd_en(accept),
    .addr (tbl_idx),
    .q    (cfg)
  );

  // write request for the current step
  always_comb begin
    kind = WK_NONE;
    mode = BYP_CODE;
    post = cfg.post;
    case (state)
      ST_BYP:   kind = WK_MODE;
      ST_DIVP1: begin kind = WK_CTL; post = 5'(cfg.post + 5'd1); end
      ST_DIV:   kind = WK_CTL;
      ST_FSEL:  kind = WK_FSEL;
      ST_LOCK:  begin kind = WK_MODE; mode = LOCK_CODE; end
      default:  ;
    endcase
  end

  pll_reseq_wr #(
    .AW      (AW),
    .EN_ADDR (EN_ADDR),
    .CTL_ADDR(CTL_ADDR),
    .EN_INIT (EN_INIT),
    .CTL_INIT(CTL_INIT)
  ) u_wr (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .mode     (mode),
    .frange   (cfg.frange),
    .post     (post),
    .mult     (cfg.mult),
    .pre      (cfg.pre),
    .wr_en_o  (wr_en_o),
    .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o)
  );

  assign tmr_clr = (state == ST_BYP) || (state == ST_LOCK);
  assign tmr_run = (state == ST_WUNL) || (state == ST_WLCK);

  pll_reseq_tmr #(.CW(LIM_W)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .clr    (tmr_clr),
    .run    (tmr_run),
    .limit  (lim_q),
    .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      wa_q   <= 1'b0;
      lim_q  <= '0;
    end else begin
      if (clear_i) begin
        done_o <= 1'b0;
        err_o  <= 1'b0;
      end
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_BYP;
          wa_q  <= wa_en_i;
          lim_q <= wait_lim_i;
        end
        ST_BYP:  state <= ST_WUNL;
        ST_WUNL: begin
          if (!status_i) state <= wa_q ? ST_DIVP1 : ST_DIV;
          else if (tmr_exp) begin
            state <= ST_IDLE;
            err_o <= 1'b1;
          end
        end
        ST_DIVP1: state <= ST_DIV;
        ST_DIV:   state <= ST_FSEL;
        ST_FSEL:  state <= ST_LOCK;
        ST_LOCK:  state <= ST_WLCK;
        ST_WLCK: begin
          if (status_i) begin
            state  <= ST_IDLE;
            done_o <= 1'b1;
          end else if (tmr_exp) begin
            state <= ST_IDLE;
            err_o <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_reseq_chk.sv
module pll_reseq_chk #(
  parameter int            AW       = 4,
  parameter logic [AW-1:0] EN_ADDR  = 4'h0,
  parameter logic [AW-1:0] CTL_ADDR = 4'h4,
  parameter logic [2:0]    BYP_CODE = 3'b101
) (
  input logic          clk,
  input logic          rst,
  input logic          clear_i,
  input logic          status_i,
  input logic          done_o,
  input logic          err_o,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [2:0]    wr_mode,
  input logic          busy
);

  a_r11_flags_excl: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));

  a_r9_no_write_on_err: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !wr_en_o);

  a_r8_done_after_lock: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(status_i));

  a_r11_clear_idle: assert property (@(posedge clk) disable iff (rst)
    (clear_i && !busy) |=> (!done_o && !err_o));

  a_r11_flag_blocks_start: assert property (@(posedge clk) disable iff (rst)
    (!busy && (done_o || err_o)) |=> !busy);

  a_r4_bypass_first: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> (wr_en_o && wr_addr_o == EN_ADDR && wr_mode == BYP_CODE));

  a_r7_addr_legal: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (wr_addr_o == EN_ADDR || wr_addr_o == CTL_ADDR));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !wr_en_o);

endmodule

bind pll_reseq pll_reseq_chk #(
  .AW      (AW),
  .EN_ADDR (EN_ADDR),
  .CTL_ADDR(CTL_ADDR),
  .BYP_CODE(BYP_CODE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clear_i  (clear_i),
  .status_i (status_i),
  .done_o   (done_o),
  .err_o    (err_o),
  .wr_en_o  (wr_en_o),
  .wr_addr_o(wr_addr_o),
  .wr_mode  (wr_data_o[2:0]),
  .busy     (busy)
);

// File: tb/tb_pll_reseq.sv
`timescale 1ns/1ps
module tb_pll_reseq;

  localparam logic [3:0]  EN_A   = 4'h0;
  localparam logic [3:0]  CTL_A  = 4'h4;
  localparam logic [31:0] EN_RV  = 32'h1234_5608;
  localparam logic [31:0] CTL_RV = 32'h0000_8047;

  typedef struct packed {
    logic [2:0]  ci;
    logic        rs;
    logic [1:0]  ri;
    logic        wa;
    logic [15:0] lim;
    logic [7:0]  du;
    logic [7:0]  dl;
    logic [1:0]  oc;   // 0 done, 1 unlock timeout, 2 lock timeout
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 2'd0, 1'b0, 16'd10, 8'd0,  8'd3,  2'd0},
    '{3'd5, 1'b1, 2'd2, 1'b1, 16'd10, 8'd4,  8'd0,  2'd0},
    '{3'd7, 1'b1, 2'd1, 1'b0, 16'd8,  8'd6,  8'd6,  2'd0},
    '{3'd2, 1'b0, 2'd3, 1'b1, 16'd8,  8'd7,  8'd0,  2'd1},
    '{3'd3, 1'b1, 2'd0, 1'b1, 16'd6,  8'd1,  8'd5,  2'd2},
    '{3'd6, 1'b0, 2'd0, 1'b1, 16'd20, 8'd10, 8'd18, 2'd0},
    '{3'd4, 1'b1, 2'd2, 1'b0, 16'd4,  8'd2,  8'd2,  2'd0},
    '{3'd1, 1'b1, 2'd1, 1'b1, 16'd3,  8'd0,  8'd1,  2'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, clear_i = 1'b0;
  logic [2:0]  clk_idx_i = '0;
  logic        rev_sel_i = 1'b0;
  logic [1:0]  rev_idx_i = '0;
  logic        wa_en_i = 1'b0;
  logic [15:0] wait_lim_i = 16'd10;
  logic        status_i;
  logic        wr_en_o;
  logic [3:0]  wr_addr_o;
  logic [31:0] wr_data_o;
  logic        done_o, err_o;

  always #2 clk = ~clk;

  pll_reseq dut (
    .clk(clk), .rst(rst), .start_i(start_i), .clear_i(clear_i),
    .clk_idx_i(clk_idx_i), .rev_sel_i(rev_sel_i), .rev_idx_i(rev_idx_i),
    .wa_en_i(wa_en_i), .wait_lim_i(wait_lim_i), .status_i(status_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .done_o(done_o), .err_o(err_o)
  );

  // PLL model: status follows the last mode written after a delay
  int   du = 0, dl = 0;
  logic st, tgt;
  int   cd;
  always @(posedge clk) begin
    if (rst) begin
      st <= 1'b1; tgt <= 1'b1; cd <= 0;
    end else if (wr_en_o && wr_addr_o == EN_A) begin
      tgt <= (wr_data_o[2:0] == 3'b111);
      cd  <= (wr_data_o[2:0] == 3'b111) ? dl : du;
    end else if (cd != 0) begin
      cd <= cd - 1;
    end else begin
      st <= tgt;
    end
  end
  assign status_i = st;

  // write log
  logic        log_clr = 1'b0;
  logic [3:0]  la [8];
  logic [31:0] ld [8];
  int          lcnt;
  always @(posedge clk) begin
    if (log_clr) lcnt <= 0;
    else if (wr_en_o) begin
      if (lcnt < 8) begin
        la[lcnt] <= wr_addr_o;
        ld[lcnt] <= wr_data_o;
      end
      lcnt <= lcnt + 1;
    end
  end

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected writes, computed from the requirements
  logic [31:0] sh_en = EN_RV, sh_ctl = CTL_RV;
  logic [3:0]  ea [8];
  logic [31:0] ed [8];
  string       et [8];
  int          ecnt;

  task automatic push(input logic [3:0] a, input logic [31:0] d, input string t);
    ea[ecnt] = a; ed[ecnt] = d; et[ecnt] = t; ecnt++;
  endtask

  task automatic predict(input vec_t v);
    int idx;
    logic [31:0] en, c;
    logic [4:0] post;
    idx = v.rs ? 3 * int'(v.ci) + int'(v.ri) : int'(v.ci);  // R2
    post = 5'((idx % 5) + 1);                                  // R3
    ecnt = 0;
    en = sh_en; en[2:0] = 3'b101;
    push(EN_A, en, "R1/R4 bypass write");
    sh_en = en;
    if (v.oc == 2'd1) return;
    c = sh_ctl;
    c[26:16] = 11'(150 + 9 * idx);
    c[14:8]  = 7'((idx % 16) + 1);
    if (v.wa) begin
      c[31:27] = 5'(post + 5'd1);
      push(CTL_A, c, "R6 first divider write");
    end
    c[31:27] = post;
    push(CTL_A, c, "R2/R3/R5 divider write");
    sh_ctl = c;
    en[7:4] = 4'((idx + 3) % 16);
    push(EN_A, en, "R7 range write");
    en[2:0] = 3'b111;
    push(EN_A, en, "R7 lock write");
    sh_en = en;
  endtask

  task automatic run_vec(input vec_t v, input bit poke, input bit do_clear);
    int n;
    @(negedge clk);
    log_clr = 1'b1; du = int'(v.du); dl = int'(v.dl);
    clk_idx_i = v.ci; rev_sel_i = v.rs; rev_idx_i = v.ri;
    wa_en_i = v.wa; wait_lim_i = v.lim; start_i = 1'b1;
    @(negedge clk);
    log_clr = 1'b0; start_i = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      start_i = 1'b1; clk_idx_i = ~v.ci; wa_en_i = ~v.wa;
      @(negedge clk);
      start_i = 1'b0;
    end
    n = 0;
    while (!(done_o || err_o) && n < 2000) begin
      @(negedge clk); n++;
    end
    repeat (30) @(negedge clk);
    predict(v);
    chk(done_o == (v.oc == 2'd0) && err_o == (v.oc != 2'd0),
        (v.oc == 2'd0) ? "R8/R10 outcome" : "R9 timeout outcome",
        {30'd0, done_o, err_o}, {30'd0, v.oc == 2'd0, v.oc != 2'd0});
    chk(lcnt == ecnt, poke ? "R11 busy start / write count" : "R7/R9 write count",
        32'(lcnt), 32'(ecnt));
    for (int k = 0; k < ecnt && k < lcnt; k++) begin
      chk(la[k] == ea[k] && ld[k] == ed[k], et[k], ld[k], ed[k]);
    end
    if (do_clear) begin
      clear_i = 1'b1;
      @(negedge clk);
      clear_i = 1'b0;
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!done_o, "R1 done after reset", {31'd0, done_o}, 32'd0);
    chk(!err_o,  "R1 err after reset",  {31'd0, err_o},  32'd0);
    chk(!wr_en_o, "R1 strobe after reset", {31'd0, wr_en_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], (i == 1), 1'b1);
    end

    // R11: start while done is set is ignored
    run_vec(VECS[0], 1'b0, 1'b0);
    @(negedge clk);
    log_clr = 1'b1; start_i = 1'b1;
    @(negedge clk);
    log_clr = 1'b0; start_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(lcnt == 0, "R11 start with done set", 32'(lcnt), 32'd0);
    chk(done_o, "R11 done held", {31'd0, done_o}, 32'd1);

    // R11: start together with clear is ignored, flags cleared
    log_clr = 1'b1; start_i = 1'b1; clear_i = 1'b1;
    @(negedge clk);
    log_clr = 1'b0; start_i = 1'b0; clear_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(lcnt == 0, "R11 start with clear", 32'(lcnt), 32'd0);
    chk(!done_o && !err_o, "R11 flags cleared", {30'd0, done_o, err_o}, 32'd0);

    // R11: a fresh start after clearing runs normally
    run_vec(VECS[6], 1'b0, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule